// File: doc/BRIEF.md
# Priority-Indexed Shadow Context Selector

This block chooses which of eight register banks a processor core is working in. Bank 0 is the base context used by ordinary code. Banks 1 to 7 are hardware shadow contexts, and each one belongs to the interrupt priority level with the same number. When a handler is entered, the block saves the interrupted program counter, the status word, the bank index and the priority field on a small internal stack. It then moves the active bank index to the handler's bank. When the handler returns, the saved values come back in last-in-first-out order. Nested handlers therefore unwind one level at a time until the base context is active again.

The registered bank index drives the register-file bank multiplexer. The restored program counter and status word are presented for one cycle with a valid strobe. A mode input turns nesting off. While nesting is off, every handler runs in bank 7, whatever its priority, and software writes to the 3-bit priority field are dropped. The block reports whether the field is writable at the moment. Two cases are refused and raise a one-cycle error strobe: a return with nothing saved, and an entry when all eight stack slots are in use.

Top module: `shadow_ctx_sel`

## Requirements
- R1: After reset, `ctx_idx` and `cur_prio` are 0, `ret_valid` and `stk_err` are 0, and the save stack is empty.
- R2: With `nest_off`=0, an entry of priority p (1..7) that is accepted sets `ctx_idx`=p and `cur_prio`=p at the next clock edge.
- R3: With `nest_off`=1, an accepted entry of priority p sets `ctx_idx`=7 and `cur_prio`=p at the next clock edge.
- R4: A return with a non-empty stack restores, at the next edge, the `ctx_idx` and `cur_prio` that held before the matching entry. In the same cycle it drives `ret_pc` and `ret_sr` with that entry's `enter_pc` and `enter_sr`, and `ret_valid` is high for exactly that one cycle.
- R5: Nested entries are unwound in reverse order: a chain of returns passes back through each interrupted context and ends in context 0.
- R6: `prio_writable` equals the inverse of `nest_off` combinationally. When no entry or return is requested, `prio_wr_en` with `nest_off`=0 loads `prio_wr_data` into `cur_prio` at the next edge. With `nest_off`=1 the write is ignored and `cur_prio` keeps its value.
- R7: A return with an empty stack changes no state, leaves `ret_valid` at 0, and raises `stk_err` for one cycle after the edge.
- R8: The stack holds at most 8 frames. An entry when 8 frames are saved is ignored (no change to `ctx_idx`, `cur_prio` or the stack) and raises `stk_err` for one cycle.
- R9: An entry request with priority 0 has no effect and raises no error.
- R10: Requests are ranked so that an entry request beats a return request, and a return request beats a priority write. Only the highest-ranked request present in a cycle acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nest_off | input | 1 | 1 = nesting disabled: handlers use context 7 and the priority field is read-only |
| enter_req | input | 1 | Handler entry request, one cycle |
| enter_prio | input | PRIO_W (3) | Priority level of the handler being entered |
| enter_pc | input | PC_W (24) | Program counter to save on entry |
| enter_sr | input | SR_W (16) | Status word to save on entry |
| ret_req | input | 1 | Handler return request, one cycle |
| prio_wr_en | input | 1 | Software write strobe for the priority field |
| prio_wr_data | input | PRIO_W (3) | Value written to the priority field |
| ctx_idx | output | PRIO_W (3) | Registered active context index, goes to the bank multiplexer |
| cur_prio | output | PRIO_W (3) | Current priority field |
| prio_writable | output | 1 | 1 while software writes to the priority field take effect |
| ret_valid | output | 1 | One-cycle strobe marking a restored frame |
| ret_pc | output | PC_W (24) | Restored program counter, valid with `ret_valid` |
| ret_sr | output | SR_W (16) | Restored status word, valid with `ret_valid` |
| stk_err | output | 1 | One-cycle strobe for a refused return (stack empty) or refused entry (stack full) |

## Verification
Four outputs are registered and become valid at the first rising edge after the cycle in which the request is held: `ctx_idx`, `cur_prio`, the restored frame with its strobe, and the error strobe. `prio_writable` is the only combinational output, so it follows `nest_off` within the same cycle. The driver applies each request at a falling edge and pushes the state it expects after the next rising edge onto a queue. The monitor pops one entry from the queue 1 ns after every rising edge and compares it with the outputs, so each result is checked in exactly the cycle it is due and not one cycle early or late.

// File: rtl/sctx_pkg.sv
package sctx_pkg;

  // Action selected for the current cycle after ranking the requests.
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_ENTER  = 3'd1,
    OP_RETURN = 3'd2,
    OP_WRITE  = 3'd3,
    OP_FAULT  = 3'd4
  } ctx_op_e;

endpackage

// File: rtl/sctx_decode.sv
module sctx_decode
  import sctx_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic              enter_req,
  input  logic [PRIO_W-1:0] enter_prio,
  input  logic              ret_req,
  input  logic              prio_wr_en,
  input  logic              nest_off,
  input  logic              stk_full,
  input  logic              stk_empty,
  output ctx_op_e           op,
  output logic [PRIO_W-1:0] tgt_ctx
);

  localparam logic [PRIO_W-1:0] TOP_CTX = {PRIO_W{1'b1}};

  // Context a handler of level lvl runs in.
  function automatic logic [PRIO_W-1:0] ctx_for_level(
    input logic [PRIO_W-1:0] lvl,
    input logic              flat
  );
    return flat ? TOP_CTX : lvl;
  endfunction

  // Ranking: entry, then return, then priority write (R10).
  function automatic ctx_op_e rank_ops(
    input logic              en,
    input logic [PRIO_W-1:0] lvl,
    input logic              rt,
    input logic              wr,
    input logic              flat,
    input logic              full,
    input logic              empty
  );
    ctx_op_e r;
    r = OP_NONE;
    if (en) begin
      if (lvl != '0) r = full ? OP_FAULT : OP_ENTER;   // R9: level 0 dropped
    end else if (rt) begin
      r = empty ? OP_FAULT : OP_RETURN;                // R7
    end else if (wr && !flat) begin
      r = OP_WRITE;                                    // R6
    end
    return r;
  endfunction

  always_comb begin
    op      = rank_ops(enter_req, enter_prio, ret_req, prio_wr_en,
                       nest_off, stk_full, stk_empty);
    tgt_ctx = ctx_for_level(enter_prio, nest_off);
  end

endmodule

// File: rtl/sctx_lifo.sv
module sctx_lifo #(
  parameter int W     = 48,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] top_data,
  output logic         empty,
  output logic         full
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] top_idx;
  logic             do_push;
  logic             do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty && !push;
  assign wr_idx  = IDX_W'(cnt);
  assign top_idx = IDX_W'(cnt - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (do_push) begin
      cnt <= cnt + CNT_W'(1);
    end else if (do_pop) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= wr_data;
  end

  assign top_data = mem[top_idx];

  // R8: occupancy never exceeds the configured depth
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  // R5: every accepted push grows the stack by exactly one frame
  a_r5_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R7: popping an empty stack leaves it empty
  a_r7_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> empty);

endmodule

// File: rtl/sctx_state.sv
module sctx_state
  import sctx_pkg::*;
#(
  parameter int PRIO_W = 3,
  parameter int PC_W   = 24,
  parameter int SR_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctx_op_e           op,
  input  logic [PRIO_W-1:0] tgt_ctx,
  input  logic [PRIO_W-1:0] enter_prio,
  input  logic [PRIO_W-1:0] wr_data,
  input  logic [PC_W-1:0]   r_pc,
  input  logic [SR_W-1:0]   r_sr,
  input  logic [PRIO_W-1:0] r_ctx,
  input  logic [PRIO_W-1:0] r_prio,
  output logic [PRIO_W-1:0] ctx_idx,
  output logic [PRIO_W-1:0] cur_prio,
  output logic              ret_valid,
  output logic [PC_W-1:0]   ret_pc,
  output logic [SR_W-1:0]   ret_sr,
  output logic              stk_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_idx   <= '0;
      cur_prio  <= '0;
      ret_valid <= 1'b0;
      ret_pc    <= '0;
      ret_sr    <= '0;
      stk_err   <= 1'b0;
    end else begin
      ret_valid <= 1'b0;
      stk_err   <= 1'b0;
      case (op)
        OP_ENTER: begin
          ctx_idx  <= tgt_ctx;
          cur_prio <= enter_prio;
        end
        OP_RETURN: begin
          ctx_idx   <= r_ctx;
          cur_prio  <= r_prio;
          ret_valid <= 1'b1;
          ret_pc    <= r_pc;
          ret_sr    <= r_sr;
        end
        OP_WRITE: cur_prio <= wr_data;
        OP_FAULT: stk_err  <= 1'b1;
        default: ;
      endcase
    end
  end

  // R4: a return presents the popped frame in the next cycle
  a_r4_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RETURN) |=> (ret_valid && ctx_idx == $past(r_ctx)
                           && ret_pc == $past(r_pc)));

  // R7/R8: a refused request changes neither context nor priority
  a_r8_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FAULT) |=> (stk_err && $stable(ctx_idx) && $stable(cur_prio)));

endmodule

// File: rtl/shadow_ctx_sel.sv
module shadow_ctx_sel
  import sctx_pkg::*;
#(
  parameter int PRIO_W = 3,
  parameter int PC_W   = 24,
  parameter int SR_W   = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nest_off,
  input  logic              enter_req,
  input  logic [PRIO_W-1:0] enter_prio,
  input  logic [PC_W-1:0]   enter_pc,
  input  logic [SR_W-1:0]   enter_sr,
  input  logic              ret_req,
  input  logic              prio_wr_en,
  input  logic [PRIO_W-1:0] prio_wr_data,
  output logic [PRIO_W-1:0] ctx_idx,
  output logic [PRIO_W-1:0] cur_prio,
  output logic              prio_writable,
  output logic              ret_valid,
  output logic [PC_W-1:0]   ret_pc,
  output logic [SR_W-1:0]   ret_sr,
  output logic              stk_err
);

  localparam int                FRAME_W = PC_W + SR_W + 2 * PRIO_W;
  localparam logic [PRIO_W-1:0] TOP_CTX = {PRIO_W{1'b1}};

  // Named internal events for the assertions.
  ctx_op_e              op;
  logic [PRIO_W-1:0]    tgt_ctx;
  logic                 stk_full;
  logic                 stk_empty;
  logic                 ev_push;
  logic                 ev_pop;
  logic [FRAME_W-1:0]   push_frame;
  logic [FRAME_W-1:0]   top_frame;
  logic [PC_W-1:0]      r_pc;
  logic [SR_W-1:0]      r_sr;
  logic [PRIO_W-1:0]    r_ctx;
  logic [PRIO_W-1:0]    r_prio;

  assign prio_writable = !nest_off;
  assign ev_push       = (op == OP_ENTER);
  assign ev_pop        = (op == OP_RETURN);
  assign push_frame    = {enter_pc, enter_sr, ctx_idx, cur_prio};
  assign {r_pc, r_sr, r_ctx, r_prio} = top_frame;

  sctx_decode #(.PRIO_W(PRIO_W)) u_decode (
    .enter_req  (enter_req),
    .enter_prio (enter_prio),
    .ret_req    (ret_req),
    .prio_wr_en (prio_wr_en),
    .nest_off   (nest_off),
    .stk_full   (stk_full),
    .stk_empty  (stk_empty),
    .op         (op),
    .tgt_ctx    (tgt_ctx)
  );

  sctx_lifo #(.W(FRAME_W), .DEPTH(DEPTH)) u_lifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ev_push),
    .pop      (ev_pop),
    .wr_data  (push_frame),
    .top_data (top_frame),
    .empty    (stk_empty),
    .full     (stk_full)
  );

  sctx_state #(.PRIO_W(PRIO_W), .PC_W(PC_W), .SR_W(SR_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .tgt_ctx    (tgt_ctx),
    .enter_prio (enter_prio),
    .wr_data    (prio_wr_data),
    .r_pc       (r_pc),
    .r_sr       (r_sr),
    .r_ctx      (r_ctx),
    .r_prio     (r_prio),
    .ctx_idx    (ctx_idx),
    .cur_prio   (cur_prio),
    .ret_valid  (ret_valid),
    .ret_pc     (ret_pc),
    .ret_sr     (ret_sr),
    .stk_err    (stk_err)
  );

  // R2: nested mode selects the bank numbered by the handler's level
  a_r2_enter_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_req && enter_prio != '0 && !nest_off && !stk_full)
    |=> (ctx_idx == $past(enter_prio) && cur_prio == $past(enter_prio)));

  // R3: flat mode forces the top bank
  a_r3_flat_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_req && enter_prio != '0 && nest_off && !stk_full)
    |=> (ctx_idx == TOP_CTX));

  // R6: the priority field is frozen for software in flat mode
  a_r6_ro_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_off && !enter_req && !ret_req) |=> $stable(cur_prio));

  // R7: empty return flags an error and restores nothing
  a_r7_empty_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !enter_req && stk_empty)
    |=> (stk_err && !ret_valid && $stable(ctx_idx)));

  // R9: level-0 entry is inert
  a_r9_zero_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_req && enter_prio == '0)
    |=> ($stable(ctx_idx) && !stk_err && !ret_valid));

  // R4: the restore strobe only follows a return request
  a_r4_ret_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> $past(ret_req));

  // R10: an entry request never lets a return through
  a_r10_enter_wins: assert property (@(posedge clk) disable iff (!rst_n)
    enter_req |-> !ev_pop);

endmodule

// File: tb/shadow_ctx_sel_bench.sv
`timescale 1ns/1ps
module shadow_ctx_sel_bench;

  localparam int PRIO_W = 3;
  localparam int PC_W   = 24;
  localparam int SR_W   = 16;
  localparam int DEPTH  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              nest_off = 1'b0;
  logic              enter_req = 1'b0;
  logic [PRIO_W-1:0] enter_prio = '0;
  logic [PC_W-1:0]   enter_pc = '0;
  logic [SR_W-1:0]   enter_sr = '0;
  logic              ret_req = 1'b0;
  logic              prio_wr_en = 1'b0;
  logic [PRIO_W-1:0] prio_wr_data = '0;
  logic [PRIO_W-1:0] ctx_idx;
  logic [PRIO_W-1:0] cur_prio;
  logic              prio_writable;
  logic              ret_valid;
  logic [PC_W-1:0]   ret_pc;
  logic [SR_W-1:0]   ret_sr;
  logic              stk_err;

  always #2.5 clk = ~clk;

  shadow_ctx_sel #(.PRIO_W(PRIO_W), .PC_W(PC_W), .SR_W(SR_W), .DEPTH(DEPTH))
  u_shadow_ctx_sel (
    .clk(clk), .rst_n(rst_n), .nest_off(nest_off),
    .enter_req(enter_req), .enter_prio(enter_prio), .enter_pc(enter_pc),
    .enter_sr(enter_sr), .ret_req(ret_req), .prio_wr_en(prio_wr_en),
    .prio_wr_data(prio_wr_data), .ctx_idx(ctx_idx), .cur_prio(cur_prio),
    .prio_writable(prio_writable), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_sr(ret_sr), .stk_err(stk_err)
  );

  typedef struct {
    logic [PRIO_W-1:0] ctx;
    logic [PRIO_W-1:0] prio;
    logic              rv;
    logic [PC_W-1:0]   pc;
    logic [SR_W-1:0]   sr;
    logic              err;
    logic              wrt;
    string             tag;
  } exp_t;

  typedef struct {
    logic [PC_W-1:0]   pc;
    logic [SR_W-1:0]   sr;
    logic [PRIO_W-1:0] ctx;
    logic [PRIO_W-1:0] prio;
  } frm_t;

  exp_t sbq[$];
  frm_t mstk[$];
  logic [PRIO_W-1:0] m_ctx  = '0;
  logic [PRIO_W-1:0] m_prio = '0;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Driver: apply one cycle of stimulus and queue the expected outcome.
  task automatic drive(input logic en, input logic [PRIO_W-1:0] p,
                       input logic [PC_W-1:0] pc, input logic [SR_W-1:0] sr,
                       input logic rt, input logic wr,
                       input logic [PRIO_W-1:0] wd, input logic flat,
                       input string tag);
    exp_t e;
    frm_t f;
    @(negedge clk);
    enter_req = en; enter_prio = p; enter_pc = pc; enter_sr = sr;
    ret_req = rt; prio_wr_en = wr; prio_wr_data = wd; nest_off = flat;
    e.rv = 1'b0; e.err = 1'b0; e.pc = '0; e.sr = '0;
    if (en) begin
      if (p != 0) begin
        if (mstk.size() == DEPTH) e.err = 1'b1;
        else begin
          f.pc = pc; f.sr = sr; f.ctx = m_ctx; f.prio = m_prio;
          mstk.push_back(f);
          m_ctx  = flat ? 3'd7 : p;
          m_prio = p;
        end
      end
    end else if (rt) begin
      if (mstk.size() == 0) e.err = 1'b1;
      else begin
        f = mstk.pop_back();
        m_ctx = f.ctx; m_prio = f.prio;
        e.rv = 1'b1; e.pc = f.pc; e.sr = f.sr;
      end
    end else if (wr && !flat) begin
      m_prio = wd;
    end
    e.ctx = m_ctx; e.prio = m_prio; e.wrt = !flat; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle(input logic flat, input string tag);
    drive(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, flat, tag);
  endtask

  // Monitor: results are due at the first rising edge after the request.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        n_tests++;
        if (ctx_idx !== e.ctx || cur_prio !== e.prio || ret_valid !== e.rv ||
            stk_err !== e.err || prio_writable !== e.wrt ||
            (e.rv && (ret_pc !== e.pc || ret_sr !== e.sr))) begin
          n_fail++;
          $display("FAIL %s: ctx=%0d/%0d prio=%0d/%0d rv=%0b/%0b err=%0b/%0b wrt=%0b/%0b pc=%h/%h sr=%h/%h (actual/expected)",
                   e.tag, ctx_idx, e.ctx, cur_prio, e.prio, ret_valid, e.rv,
                   stk_err, e.err, prio_writable, e.wrt, ret_pc, e.pc,
                   ret_sr, e.sr);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    n_tests++;
    if (ctx_idx !== 0 || cur_prio !== 0 || ret_valid !== 0 || stk_err !== 0 ||
        prio_writable !== 1) begin
      n_fail++;
      $display("FAIL R1: ctx=%0d prio=%0d rv=%0b err=%0b wrt=%0b expected 0 0 0 0 1",
               ctx_idx, cur_prio, ret_valid, stk_err, prio_writable);
    end
    rst_n = 1'b1;
    idle(1'b0, "R1 idle after reset");

    // R2 and R5: nested entries in nested mode
    drive(1'b1, 3'd3, 24'h000100, 16'h0011, 1'b0, 1'b0, '0, 1'b0, "R2 enter 3");
    drive(1'b1, 3'd5, 24'h000200, 16'h0022, 1'b0, 1'b0, '0, 1'b0, "R2 enter 5");
    drive(1'b1, 3'd6, 24'h000300, 16'h0033, 1'b0, 1'b0, '0, 1'b0, "R5 enter 6");
    // R4 and R5: unwinding
    drive(1'b0, '0, '0, '0, 1'b1, 1'b0, '0, 1'b0, "R4 return to 5");
    drive(1'b0, '0, '0, '0, 1'b1, 1'b0, '0, 1'b0, "R5 return to 3");
    drive(1'b0, '0, '0, '0, 1'b1, 1'b0, '0, 1'b0, "R5 return to base");
    // R7: return with nothing saved
    drive(1'b0, '0, '0, '0, 1'b1, 1'b0, '0, 1'b0, "R7 empty return");
    idle(1'b0, "R7 strobe clears");

    // R6: priority writes
    drive(1'b0, '0, '0, '0, 1'b0, 1'b1, 3'd4, 1'b0, "R6 write accepted");
    drive(1'b0, '0, '0, '0, 1'b0, 1'b1, 3'd2, 1'b1, "R6 write ignored");
    drive(1'b0, '0, '0, '0, 1'b0, 1'b1, 3'd0, 1'b0, "R6 write back to 0");

    // R3: flat mode uses context 7
    drive(1'b1, 3'd2, 24'h000400, 16'h0044, 1'b0, 1'b0, '0, 1'b1, "R3 enter 2 flat");
    drive(1'b1, 3'd5, 24'h000500, 16'h0055, 1'b0, 1'b0, '0, 1'b1, "R3 enter 5 flat");
    drive(1'b0, '0, '0, '0, 1'b0, 1'b1, 3'd1, 1'b1, "R6 flat write ignored");
    drive(1'b0, '0, '0, '0, 1'b1, 1'b0, '0, 1'b1, "R3 return flat");
    drive(1'b0, '0, '0, '0, 1'b1, 1'b0, '0, 1'b1, "R3 return to base");

    // R9: level zero entry
    drive(1'b1, 3'd0, 24'h000600, 16'h0066, 1'b0, 1'b0, '0, 1'b0, "R9 level 0 entry");

    // R10: ranking of simultaneous requests
    drive(1'b1, 3'd4, 24'h000700, 16'h0077, 1'b1, 1'b1, 3'd1, 1'b0, "R10 entry beats return");
    drive(1'b0, '0, '0, '0, 1'b1, 1'b1, 3'd6, 1'b0, "R10 return beats write");

    // R8: fill the stack, overflow, then drain
    for (int i = 0; i < DEPTH; i++)
      drive(1'b1, 3'(1 + (i % 7)), 24'(24'h010000 + i), 16'(16'h0A00 + i),
            1'b0, 1'b0, '0, 1'b0, "R8 fill");
    drive(1'b1, 3'd7, 24'h0FFFFF, 16'hFFFF, 1'b0, 1'b0, '0, 1'b0, "R8 entry when full");
    idle(1'b0, "R8 strobe clears");
    for (int i = 0; i < DEPTH; i++)
      drive(1'b0, '0, '0, '0, 1'b1, 1'b0, '0, 1'b0, "R5 drain");
    drive(1'b0, '0, '0, '0, 1'b1, 1'b0, '0, 1'b0, "R7 return after drain");
    idle(1'b0, "R1 settle");
    idle(1'b0, "R1 settle");

    @(posedge clk);
    #2;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule